// File: doc/BRIEF.md
# Chirp Frequency Word Sequencer

This block feeds a frequency synthesizer's tuning input during a stepped chirp, one 32-bit frequency word per sample strobe. Before playback, a small register port loads the chirp's frequencies into an internal list and sets three lengths: the step count `N`, the data length `DL` and the memory depth `MD`. After a valid start, every strobe produces one word, and a position counter steps from 0 to `MD-1` and then wraps back to 0.

Within the first `DL` positions, the chirp list repeats cyclically. When `DL` is not a whole multiple of `N`, the final pass is cut short. From position `DL` up to `MD-1`, the block repeats the first frequency of the list. An option ties the data length to the memory depth, which removes the padding region. Three single-strobe markers flag the end of each chirp pass, the end of the data-length span and the end of the memory-depth span.

Top module: `chirp_seq`

## Requirements
- R1: A write with `wr_en=1` while stopped updates the field chosen by `wr_sel`: 0 sets step count N, 1 sets data length DL, 2 sets memory depth MD, 3 stores `wr_data` as list word `wr_idx`, and 4 sets the tie option from bit 0 of `wr_data`.
- R2: A start request while stopped is refused when the effective configuration breaks 1 ≤ N ≤ DL ≤ MD, when N exceeds the list depth, or when MD exceeds 2^19. A refused start sets `cfg_err=1` and leaves `running=0`. An accepted start sets `running=1` and clears `cfg_err`.
- R3: `freq_vld` pulses for exactly one clock, one clock after each strobe taken while running. It stays low when there is no strobe.
- R4: For a position p < DL, the output word is list[p mod N].
- R5: For a position DL ≤ p < MD, the output word is list[0].
- R6: After position MD-1, the next strobe plays position 0, and the sequence repeats indefinitely.
- R7: With the tie option set, DL is taken equal to MD, whatever the value written for DL.
- R8: Each marker is high only together with `freq_vld`. `chirp_end` is high when p < DL and p mod N = N-1. `dl_end` is high when p = DL-1. `md_end` is high when p = MD-1.
- R9: Configuration and list writes made while running are ignored.
- R10: `stop` halts playback, and strobes are then ignored. Every accepted start begins again at position 0.
- R11: After reset, `running`, `cfg_err`, `freq_vld`, the markers and `freq_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Field select: 0 N, 1 DL, 2 MD, 3 list word, 4 options |
| wr_idx | input | IDX_W | List index for list-word writes |
| wr_data | input | WORD_W | Write data |
| start | input | 1 | Start request |
| stop | input | 1 | Stop request |
| strobe | input | 1 | Sample strobe that advances playback |
| freq_out | output | WORD_W | Registered frequency word |
| freq_vld | output | 1 | One-clock pulse aligned with a new word |
| chirp_end | output | 1 | Last step of a chirp pass |
| dl_end | output | 1 | Last position of the data-length span |
| md_end | output | 1 | Last position of the memory-depth span |
| running | output | 1 | Playback active |
| cfg_err | output | 1 | The last start was refused |

## Verification
The bench uses the default parameters: a 64-entry list and a 20-bit position counter. With these, it can play a full 40-step chirp against DL=50 and MD=64, which covers a truncated second pass followed by 14 padding words. It also plays a 10/12/16 setup, a setup where N equals DL equals MD, and a tied setup with N=5 in which 64 is not a multiple of 5. Each of these runs through two full memory-depth spans, so the wrap is checked as well. Refused configurations include N above DL, DL above MD, N of zero and N above the list depth of 64.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

    localparam int WORD_W   = 32;
    localparam int POS_LOG2 = 19;

    typedef enum logic [2:0] {
        SEL_STEPS  = 3'd0,
        SEL_DLEN   = 3'd1,
        SEL_MDEPTH = 3'd2,
        SEL_LIST   = 3'd3,
        SEL_OPT    = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic chirp_end;
        logic dl_end;
        logic md_end;
    } marks_t;

    // Legal when 1 <= n <= dl <= md, n fits the list and md fits the range
    function automatic logic cfg_ok(input logic [31:0] n, input logic [31:0] dl,
                                    input logic [31:0] md, input logic [31:0] n_lim,
                                    input logic [31:0] md_lim);
        return (n != 0) && (n <= n_lim) && (n <= dl) && (dl <= md) && (md <= md_lim);
    endfunction

endpackage

// File: rtl/chirp_cfg_regs.sv
module chirp_cfg_regs
    import chirp_seq_pkg::*;
#(
    parameter int CNT_W      = POS_LOG2 + 1,
    parameter int LIST_DEPTH = 64,
    parameter int DATA_W     = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock,
    output logic [CNT_W-1:0]  steps,
    output logic [CNT_W-1:0]  dlen,
    output logic [CNT_W-1:0]  mdepth,
    output logic              ok
);
    localparam logic [31:0] MD_LIM = 32'(1) << POS_LOG2;

    logic [CNT_W-1:0] steps_q, dlen_q, mdep_q;
    logic             n_big, d_big, m_big, tie_q;
    logic             data_big;

    assign data_big = |wr_data[DATA_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            steps_q <= '0;
            dlen_q  <= '0;
            mdep_q  <= '0;
            n_big   <= 1'b0;
            d_big   <= 1'b0;
            m_big   <= 1'b0;
            tie_q   <= 1'b0;
        end else if (wr_en && !lock) begin
            case (cfg_sel_e'(wr_sel))
                SEL_STEPS:  begin steps_q <= wr_data[CNT_W-1:0]; n_big <= data_big; end
                SEL_DLEN:   begin dlen_q  <= wr_data[CNT_W-1:0]; d_big <= data_big; end
                SEL_MDEPTH: begin mdep_q  <= wr_data[CNT_W-1:0]; m_big <= data_big; end
                SEL_OPT:    tie_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    assign steps  = steps_q;
    assign mdepth = mdep_q;
    assign dlen   = tie_q ? mdep_q : dlen_q;

    assign ok = !n_big && !m_big && (tie_q || !d_big) &&
                cfg_ok(32'(steps), 32'(dlen), 32'(mdepth), 32'(LIST_DEPTH), MD_LIM);

endmodule

// File: rtl/chirp_list_ram.sv
module chirp_list_ram #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/chirp_pos_ctr.sv
module chirp_pos_ctr
    import chirp_seq_pkg::*;
#(
    parameter int CNT_W = POS_LOG2 + 1,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    input  logic [CNT_W-1:0] steps,
    input  logic [CNT_W-1:0] dlen,
    input  logic [CNT_W-1:0] mdepth,
    output logic [CNT_W-1:0] pos,
    output logic [IDX_W-1:0] idx,
    output logic             in_dl,
    output marks_t           marks
);
    logic last_pos, last_idx;

    assign last_pos = (pos == mdepth - CNT_W'(1));
    assign last_idx = ({{(CNT_W-IDX_W){1'b0}}, idx} == steps - CNT_W'(1));
    assign in_dl    = (pos < dlen);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos <= '0;
            idx <= '0;
        end else if (adv) begin
            pos <= last_pos ? '0 : pos + CNT_W'(1);
            idx <= (last_pos || last_idx) ? '0 : idx + IDX_W'(1);
        end
    end

    always_comb begin
        marks.chirp_end = in_dl && last_idx;
        marks.dl_end    = (pos == dlen - CNT_W'(1));
        marks.md_end    = last_pos;
    end

endmodule

// File: rtl/chirp_seq.sv
module chirp_seq
    import chirp_seq_pkg::*;
#(
    parameter int LIST_DEPTH = 64,
    parameter int DATA_W     = WORD_W,
    parameter int CNT_W      = POS_LOG2 + 1,
    parameter int IDX_W      = $clog2(LIST_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic              stop,
    input  logic              strobe,
    output logic [DATA_W-1:0] freq_out,
    output logic              freq_vld,
    output logic              chirp_end,
    output logic              dl_end,
    output logic              md_end,
    output logic              running,
    output logic              cfg_err
);
    logic [CNT_W-1:0]  steps, dlen, mdepth, pos;
    logic [IDX_W-1:0]  idx, rd_addr;
    logic [DATA_W-1:0] rd_word;
    logic              ok, in_dl, adv, go;
    marks_t            marks, marks_q;

    assign adv = strobe && running && !stop;
    assign go  = start && !stop && !running && ok;

    chirp_cfg_regs #(.CNT_W(CNT_W), .LIST_DEPTH(LIST_DEPTH), .DATA_W(DATA_W)) u_cfg (
        .clk, .rst, .wr_en, .wr_sel, .wr_data, .lock(running),
        .steps, .dlen, .mdepth, .ok
    );

    chirp_list_ram #(.WORD_W(DATA_W), .DEPTH(LIST_DEPTH), .IDX_W(IDX_W)) u_ram (
        .clk,
        .we    (wr_en && !running && (cfg_sel_e'(wr_sel) == SEL_LIST)),
        .waddr (wr_idx),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    chirp_pos_ctr #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_pos (
        .clk, .rst, .clear(go), .adv, .steps, .dlen, .mdepth,
        .pos, .idx, .in_dl, .marks
    );

    // Padding region reads the head of the list
    assign rd_addr = in_dl ? idx : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cfg_err <= 1'b0;
        end else if (stop) begin
            running <= 1'b0;
        end else if (start && !running) begin
            running <= ok;
            cfg_err <= !ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_out <= '0;
            freq_vld <= 1'b0;
            marks_q  <= '0;
        end else begin
            freq_vld <= adv;
            marks_q  <= adv ? marks : '0;
            if (adv) freq_out <= rd_word;
        end
    end

    assign chirp_end = marks_q.chirp_end;
    assign dl_end    = marks_q.dl_end;
    assign md_end    = marks_q.md_end;

endmodule

// File: rtl/chirp_seq_chk.sv
module chirp_seq_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             strobe,
    input logic             stop,
    input logic             running,
    input logic             freq_vld,
    input logic             chirp_end,
    input logic             dl_end,
    input logic             md_end,
    input logic             cfg_err,
    input logic [CNT_W-1:0] pos,
    input logic [CNT_W-1:0] mdepth
);
    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        freq_vld |-> $past(strobe && running && !stop)); // R3

    AST_MARK_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
        (chirp_end || dl_end || md_end) |-> freq_vld); // R8

    AST_POS_BELOW_DEPTH: assert property (@(posedge clk) disable iff (rst)
        running |-> (pos < mdepth)); // R6

    AST_ERR_NOT_RUNNING: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !running); // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> $stable(mdepth)); // R9

endmodule

bind chirp_seq chirp_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk, .rst, .strobe, .stop, .running, .freq_vld, .chirp_end, .dl_end,
    .md_end, .cfg_err, .pos, .mdepth
);

// File: tb/chirp_seq_tb.sv
module chirp_seq_tb;

    localparam int IDX_W = 6;

    typedef struct packed {
        logic [31:0] n;
        logic [31:0] dl;
        logic [31:0] md;
        logic        tie;
        logic        bad;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'd10, 32'd12, 32'd16, 1'b0, 1'b0},
        '{32'd40, 32'd50, 32'd64, 1'b0, 1'b0},
        '{32'd5,  32'd9,  32'd64, 1'b1, 1'b0},
        '{32'd13, 32'd12, 32'd16, 1'b0, 1'b1},
        '{32'd4,  32'd20, 32'd16, 1'b0, 1'b1},
        '{32'd0,  32'd4,  32'd4,  1'b0, 1'b1},
        '{32'd65, 32'd70, 32'd80, 1'b0, 1'b1},
        '{32'd8,  32'd8,  32'd8,  1'b0, 1'b0}
    };

    logic clk = 0, rst = 1;
    logic wr_en = 0, start = 0, stop = 0, strobe = 0;
    logic [2:0] wr_sel = 0;
    logic [IDX_W-1:0] wr_idx = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] freq_out;
    logic freq_vld, chirp_end, dl_end, md_end, running, cfg_err;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chirp_seq u_dut (
        .clk, .rst, .wr_en, .wr_sel, .wr_idx, .wr_data, .start, .stop, .strobe,
        .freq_out, .freq_vld, .chirp_end, .dl_end, .md_end, .running, .cfg_err
    );

    function automatic logic [31:0] wv(input int i);
        return 32'hA500_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    task automatic chk(input bit good, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_idx = IDX_W'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
    endtask

    // One strobe; outputs sampled at the following negedge
    task automatic step(output logic [31:0] w, output logic v, output logic [2:0] mk);
        @(negedge clk); strobe = 1;
        @(negedge clk); strobe = 0;
        w = freq_out; v = freq_vld; mk = {chirp_end, dl_end, md_end};
    endtask

    task automatic run_cfg(input vec_t c);
        int dl;
        logic [31:0] w; logic v; logic [2:0] mk;
        dl = c.tie ? int'(c.md) : int'(c.dl);
        for (int k = 0; k < 2 * int'(c.md); k++) begin
            int p;
            logic [31:0] ew;
            logic [2:0] em;
            p  = k % int'(c.md);
            ew = (p < dl) ? wv(p % int'(c.n)) : wv(0);
            em = {(p < dl) && (p % int'(c.n) == int'(c.n) - 1), p == dl - 1,
                  p == int'(c.md) - 1};
            step(w, v, mk);
            chk(v == 1'b1, "R3 vld", 32'(v), 32'd1);
            // R4 chirp region, R5 pad region, R6 wrap, R7 tie
            chk(w == ew, (p < dl) ? (c.tie ? "R4/R7 word" : "R4 word") :
                (k >= int'(c.md) ? "R5/R6 word" : "R5 word"), w, ew);
            chk(mk == em, "R8 markers", 32'(mk), 32'(em));
            if (k == 0) begin
                @(negedge clk);
                chk(freq_vld == 1'b0, "R3 single pulse", 32'(freq_vld), 32'd0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] w; logic v; logic [2:0] mk;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(running == 0 && cfg_err == 0, "R11 status", {30'd0, running, cfg_err}, 32'd0);
        chk(freq_vld == 0 && {chirp_end, dl_end, md_end} == 0, "R11 strobes",
            {28'd0, freq_vld, chirp_end, dl_end, md_end}, 32'd0);
        chk(freq_out == 0, "R11 word", freq_out, 32'd0);

        for (int i = 0; i < 64; i++) wr(3'd3, i, wv(i)); // R1 list load

        for (int t = 0; t < NV; t++) begin
            wr(3'd0, 0, VECS[t].n);
            wr(3'd1, 0, VECS[t].dl);
            wr(3'd2, 0, VECS[t].md);
            wr(3'd4, 0, {31'd0, VECS[t].tie});
            pulse_start();
            chk(running == !VECS[t].bad, "R2 running", 32'(running), 32'(!VECS[t].bad));
            chk(cfg_err == VECS[t].bad, "R2 cfg_err", 32'(cfg_err), 32'(VECS[t].bad));
            if (VECS[t].bad) begin
                step(w, v, mk);
                chk(v == 0, "R2 no playback", 32'(v), 32'd0);
            end else begin
                run_cfg(VECS[t]);
                pulse_stop();
            end
        end

        // R9: writes during playback are ignored
        wr(3'd0, 0, 32'd10); wr(3'd1, 0, 32'd12); wr(3'd2, 0, 32'd16); wr(3'd4, 0, 32'd0);
        pulse_start();
        for (int k = 0; k < 3; k++) step(w, v, mk);
        wr(3'd3, 0, 32'hDEAD_BEEF);
        wr(3'd2, 0, 32'd8);
        for (int k = 3; k < 13; k++) step(w, v, mk);
        chk(w == wv(0), "R9 list write ignored", w, wv(0));
        for (int k = 13; k < 16; k++) step(w, v, mk);
        chk(mk[0] == 1'b1, "R9 depth write ignored", 32'(mk), 32'd1);
        // R10 stop then strobe ignored
        pulse_stop();
        step(w, v, mk);
        chk(v == 0 && running == 0, "R10 stopped", 32'(v), 32'd0);
        // R1 list write accepted while stopped, R10 restart at position 0
        wr(3'd3, 0, 32'hDEAD_BEEF);
        pulse_start();
        for (int k = 0; k < 5; k++) step(w, v, mk);
        chk(w == wv(4), "R4 mid run", w, wv(4));
        pulse_stop();
        pulse_start();
        step(w, v, mk);
        chk(w == 32'hDEAD_BEEF, "R10/R1 restart at 0", w, 32'hDEAD_BEEF);
        // R7: tie ignores written DL (DL=12 written, MD=16 tied)
        pulse_stop();
        wr(3'd3, 0, wv(0));
        wr(3'd4, 0, 32'd1);
        pulse_start();
        for (int k = 0; k < 15; k++) step(w, v, mk);
        chk(w == wv(4), "R7 tie word at 14", w, wv(4));
        step(w, v, mk);
        chk(mk == 3'b011, "R7 tie markers at 15", 32'(mk), 32'b011);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule